// File: doc/BRIEF.md
# Minimal Accumulator CPU Core

This block is a very small 8-bit processor with one accumulator. It is meant as a compact controller. A 16-word by 8-bit RAM holds both the program and its data. Every word moves between the internal registers over one shared 8-bit bus. The registers are:

- a program counter
- a memory address register
- an instruction register
- an accumulator
- an operand register
- an output register

A single adder/subtractor combines the accumulator with the operand register. Every instruction is one byte. The upper four bits select one of five operations, and the lower four bits name a RAM word.

The program is written through a load port while the core is held in reset. After reset is released, the core fetches and executes from address 0. Each instruction takes exactly six clock cycles and is stepped by a one-hot ring sequencer. Results appear on an 8-bit output register meant for binary LEDs.

`out_valid` pulses for one cycle each time the output register is loaded. It has no ready partner: the core never stalls. A consumer that wants every value must take it during the pulse, although the register holds the value until the next output instruction or reset. A halt instruction freezes the sequencer until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_leds` is 0, `out_valid` is 0 and `halted` is 0. Execution then starts from RAM address 0 with the accumulator at 0.
- R2: While `rst_n` is low, a cycle with `prog_we` high writes `prog_data` into RAM word `prog_addr`. While `rst_n` is high, `prog_we` is ignored and RAM contents are unchanged.
- R3: An instruction byte carries the opcode in bits 7:4 and the RAM address in bits 3:0. The opcodes are 0x0 load, 0x1 add, 0x2 subtract, 0xE output and 0xF halt. Any other opcode changes no register and still takes six cycles.
- R4: Every instruction takes six cycles. Counting rising edges from 1 after `rst_n` goes high, instruction k (from 0) occupies edges 6k+1 to 6k+6.
- R5: Load (0x0) sets the accumulator to RAM[addr].
- R6: Add (0x1) sets the accumulator to (accumulator + RAM[addr]) mod 256.
- R7: Subtract (0x2) sets the accumulator to (accumulator - RAM[addr]) mod 256, in two's complement.
- R8: Output (0xE) of instruction k copies the accumulator to `out_leds` at edge 6k+4, and `out_valid` is high for exactly the cycle after that edge. At all other times `out_leds` keeps its value.
- R9: Halt (0xF) of instruction k raises `halted` at edge 6k+4. `halted` then stays high, and no output changes until reset.
- R10: The program counter wraps from 15 to 0, so a program without a halt runs on from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; also enables the load port |
| prog_we | input | 1 | Load-port write strobe, honoured only in reset |
| prog_addr | input | 4 | Load-port RAM word address |
| prog_data | input | 8 | Load-port write data |
| out_leds | output | 8 | Output register, binary LED value |
| out_valid | output | 1 | One-cycle pulse when `out_leds` is loaded |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
An output instruction at index k loads `out_leds` and raises `out_valid` at edge 6k+4, and a halt at index k raises `halted` at the same edge. These timings follow from three fetch states and the first execute state. The bench counts rising edges from the release of reset and runs its own interpreter of the program to predict each output value with its edge number. It samples on the falling edge and requires every `out_valid` pulse to match the next predicted item in both value and edge. For a halt, it checks `halted` one edge before and on the predicted edge. It then checks that nothing moves for many cycles afterwards.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int N_STEPS = 6;

  localparam logic [3:0] OPC_LOAD = 4'h0;
  localparam logic [3:0] OPC_ADD  = 4'h1;
  localparam logic [3:0] OPC_SUB  = 4'h2;
  localparam logic [3:0] OPC_SHOW = 4'hE;
  localparam logic [3:0] OPC_STOP = 4'hF;

  typedef struct packed {
    logic pc_oe;
    logic pc_inc;
    logic mar_ld;
    logic ram_oe;
    logic ir_ld;
    logic ir_oe;
    logic acc_ld;
    logic acc_oe;
    logic opd_ld;
    logic alu_oe;
    logic alu_sub;
    logic out_ld;
    logic stop;
  } ctrl_t;

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  logic [DW-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    y     = a + b_eff + {{(DW-1){1'b0}}, sub};
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
#(
  parameter int NS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  output ctrl_t      ctrl,
  output logic       halted
);
  logic [NS-1:0] ring;
  logic          is_mem_op;
  logic          is_arith;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring   <= {{(NS-1){1'b0}}, 1'b1};
      halted <= 1'b0;
    end else if (!halted) begin
      ring <= {ring[NS-2:0], ring[NS-1]};
      if (ctrl.stop) halted <= 1'b1;
    end
  end

  assign is_arith  = (opcode == OPC_ADD) || (opcode == OPC_SUB);
  assign is_mem_op = is_arith || (opcode == OPC_LOAD);

  always_comb begin
    ctrl = '0;
    if (!halted) begin
      if (ring[0]) begin
        ctrl.pc_oe  = 1'b1;
        ctrl.mar_ld = 1'b1;
      end
      if (ring[1]) ctrl.pc_inc = 1'b1;
      if (ring[2]) begin
        ctrl.ram_oe = 1'b1;
        ctrl.ir_ld  = 1'b1;
      end
      if (ring[3]) begin
        if (is_mem_op) begin
          ctrl.ir_oe  = 1'b1;
          ctrl.mar_ld = 1'b1;
        end
        if (opcode == OPC_SHOW) begin
          ctrl.acc_oe = 1'b1;
          ctrl.out_ld = 1'b1;
        end
        if (opcode == OPC_STOP) ctrl.stop = 1'b1;
      end
      if (ring[4]) begin
        if (opcode == OPC_LOAD) begin
          ctrl.ram_oe = 1'b1;
          ctrl.acc_ld = 1'b1;
        end
        if (is_arith) begin
          ctrl.ram_oe = 1'b1;
          ctrl.opd_ld = 1'b1;
        end
      end
      if (ring[5] && is_arith) begin
        ctrl.alu_oe  = 1'b1;
        ctrl.acc_ld  = 1'b1;
        ctrl.alu_sub = (opcode == OPC_SUB);
      end
    end
  end

  // R4
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ring));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(ring));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] out_leds,
  output logic              out_valid,
  output logic              halted
);
  localparam int PAD_W = DATA_W - ADDR_W;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] opd;
  logic [DATA_W-1:0] bus;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] alu_y;
  logic              ram_we;

  assign ram_we = prog_we && !rst_n;

  acc_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (mar),
    .rdata (ram_q)
  );

  acc_alu #(.DW(DATA_W)) u_alu (
    .a   (acc),
    .b   (opd),
    .sub (ctrl.alu_sub),
    .y   (alu_y)
  );

  acc_seq #(.NS(N_STEPS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir[DATA_W-1 -: 4]),
    .ctrl   (ctrl),
    .halted (halted)
  );

  always_comb begin
    bus = '0;
    if (ctrl.pc_oe)  bus = {{PAD_W{1'b0}}, pc};
    if (ctrl.ram_oe) bus = ram_q;
    if (ctrl.ir_oe)  bus = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
    if (ctrl.acc_oe) bus = acc;
    if (ctrl.alu_oe) bus = alu_y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      mar       <= '0;
      ir        <= '0;
      acc       <= '0;
      opd       <= '0;
      out_leds  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (ctrl.pc_inc) pc       <= pc + 1'b1;
      if (ctrl.mar_ld) mar      <= bus[ADDR_W-1:0];
      if (ctrl.ir_ld)  ir       <= bus;
      if (ctrl.acc_ld) acc      <= bus;
      if (ctrl.opd_ld) opd      <= bus;
      if (ctrl.out_ld) out_leds <= bus;
      out_valid <= ctrl.out_ld;
    end
  end

  // R4
  bus_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.pc_oe, ctrl.ram_oe, ctrl.ir_oe, ctrl.acc_oe, ctrl.alu_oe}));

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_leds) |-> out_valid);

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.pc_inc |=> pc == $past(pc) + 1'b1);

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int CLK_PERIOD = 10;

  typedef logic [7:0] img_t [16];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_we = 1'b0;
  logic [3:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic [7:0] out_leds;
  logic       out_valid;
  logic       halted;

  int total = 0;
  int passed = 0;
  int cyc = 0;
  bit done = 1'b0;

  int         exp_cyc_q [$];
  logic [7:0] exp_val_q [$];
  string      exp_tag_q [$];

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .out_leds(out_leds), .out_valid(out_valid),
    .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
  endtask

  // monitor: every output pulse is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_val_q.size() == 0) begin
        check(1'b0, "R8", "unexpected output pulse", int'(out_leds), 0);
      end else begin
        automatic int         ec = exp_cyc_q.pop_front();
        automatic logic [7:0] ev = exp_val_q.pop_front();
        automatic string      et = exp_tag_q.pop_front();
        check(out_leds == ev, et, "output value", int'(out_leds), int'(ev));
        check(cyc == ec, "R4", "output edge", cyc, ec);
      end
    end
  end

  // reference interpreter derived from R3..R10
  task automatic model_run(input img_t m, input int max_instr, input string tag,
                           output int halt_idx, output logic [7:0] last_out);
    logic [3:0] pc;
    logic [7:0] acc;
    pc = '0;
    acc = '0;
    halt_idx = -1;
    last_out = '0;
    for (int k = 0; k < max_instr; k++) begin
      logic [7:0] w;
      w = m[pc];
      pc = pc + 4'd1;
      if (w[7:4] == 4'h0) acc = m[w[3:0]];
      else if (w[7:4] == 4'h1) acc = acc + m[w[3:0]];
      else if (w[7:4] == 4'h2) acc = acc - m[w[3:0]];
      else if (w[7:4] == 4'hE) begin
        exp_cyc_q.push_back(6*k + 4);
        exp_val_q.push_back(acc);
        exp_tag_q.push_back(tag);
        last_out = acc;
      end else if (w[7:4] == 4'hF) begin
        halt_idx = k;
        break;
      end
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic run_prog(input img_t m, input int max_instr, input string tag,
                          input bit late_write);
    int hidx;
    logic [7:0] lastv;
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 16; a++) begin
      prog_we = 1'b1;
      prog_addr = 4'(a);
      prog_data = m[a];
      @(negedge clk);
    end
    prog_we = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_leds == 8'h00, "R1", "out_leds in reset", int'(out_leds), 0);
    check(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    model_run(m, max_instr, tag, hidx, lastv);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_leds == 8'h00 && !out_valid && !halted, "R1", "state after release",
          int'(out_leds), 0);
    if (late_write) begin
      // R2: writes while running must be ignored
      wait_cyc(2);
      prog_we = 1'b1;
      prog_addr = 4'hE;
      prog_data = 8'hA5;
      repeat (3) @(negedge clk);
      prog_we = 1'b0;
    end
    if (hidx >= 0) begin
      wait_cyc(6*hidx + 3);
      check(halted == 1'b0, "R9", "halted before halt edge", int'(halted), 0);
      wait_cyc(6*hidx + 4);
      check(halted == 1'b1, "R9", "halted on halt edge", int'(halted), 1);
      wait_cyc(6*hidx + 40);
      check(halted == 1'b1, "R9", "halted stays high", int'(halted), 1);
      check(out_leds == lastv, "R9", "out_leds frozen after halt",
            int'(out_leds), int'(lastv));
    end else begin
      wait_cyc(6*max_instr + 2);
      check(halted == 1'b0, "R10", "no halt while wrapping", int'(halted), 0);
    end
    check(exp_val_q.size() == 0, "R8", "pending outputs not seen",
          exp_val_q.size(), 0);
    exp_val_q.delete();
    exp_cyc_q.delete();
    exp_tag_q.delete();
  endtask

  initial begin
    img_t m;
    repeat (3) @(negedge clk);

    // R5 R6 R7 R8: load, add, output, subtract, output, halt
    m = '{default: 8'h00};
    m[0] = 8'h09; m[1] = 8'h1A; m[2] = 8'hE0; m[3] = 8'h2B; m[4] = 8'hE0;
    m[5] = 8'hF0; m[9] = 8'h1C; m[10] = 8'h0E; m[11] = 8'h05;
    run_prog(m, 64, "R6/R7", 1'b0);

    // R6 R7: modulo-256 wrap on add and borrow on subtract
    m = '{default: 8'h00};
    m[0] = 8'h0D; m[1] = 8'h1E; m[2] = 8'hE0; m[3] = 8'h2F; m[4] = 8'hE0;
    m[5] = 8'hF0; m[13] = 8'hFF; m[14] = 8'h02; m[15] = 8'h05;
    run_prog(m, 64, "R7", 1'b0);

    // R3: unlisted opcodes change nothing
    m = '{default: 8'h00};
    m[0] = 8'h0E; m[1] = 8'h5E; m[2] = 8'hA3; m[3] = 8'hE0; m[4] = 8'h3E;
    m[5] = 8'hE0; m[6] = 8'hF0; m[14] = 8'h33;
    run_prog(m, 64, "R3", 1'b0);

    // R2: load port ignored while running
    m = '{default: 8'h00};
    m[0] = 8'h40; m[1] = 8'h40; m[2] = 8'h40; m[3] = 8'h0E; m[4] = 8'hE0;
    m[5] = 8'hF0; m[14] = 8'h5A;
    run_prog(m, 64, "R2", 1'b1);

    // R10: no halt, program counter wraps and keeps running
    m = '{default: 8'h40};
    m[0] = 8'h1E; m[1] = 8'hE0; m[14] = 8'h03;
    run_prog(m, 40, "R10", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

endmodule